// File: doc/BRIEF.md
# Audio Receive Sample FIFO

This block sits between an audio converter and a host bus. It buffers incoming PCM samples in a circular store and widens each one to a 32-bit word as it is stored. The converter offers a sample (or a left/right pair) together with a valid strobe. The host reads the oldest entry at any time through a non-destructive peek view. A pop strobe removes that entry.

Software configures several things: the channel mode (off, left only, right only, or a stereo pair), the word length, and whether widening uses zeros or the sign bit. It also sets a trigger level. While the fill count is above that level, a trigger flag is raised, and that flag can drive a DMA request. Two debug controls are provided. A held clear keeps the store empty for as long as it is asserted. A freeze drops all converter writes without moving the write pointer. Four event sources feed a sticky interrupt request register, which has set, write-1-to-clear, mask and masked views and a single interrupt line.

Top module: `pcm_rx_fifo`

## Requirements
- R1: After reset the fill count, both pointers and all interrupt request bits are 0.
- R2: With a valid strobe, channel mode 1 stores the left sample and mode 2 stores the right sample, one entry per strobe. Mode 0 stores nothing.
- R3: In mode 3 a valid strobe stores two consecutive entries, the left sample first and then the right sample.
- R4: Word length code 0/1/2/3 selects 16/18/20/24 significant input bits. The stored word is those bits widened to 32 bits, with zeros when the extension bit is 0 or with the top significant bit when it is 1.
- R5: The head output always shows the oldest entry. A pop strobe on a non-empty store removes it, and the entry behind it appears on the next cycle.
- R6: The fill count is the number of entries held and ranges from 0 to the depth (255 by default). The read and write pointers advance by one per entry and wrap from depth-1 to 0.
- R7: While clear is 1, the count and both pointers are held at 0, and writes and pops have no effect. Entries written after clear returns to 0 are stored normally.
- R8: While freeze is 1, converter writes are dropped, the write pointer does not move and no overflow is flagged. Pops still work.
- R9: A mono write to a full store, or a stereo pair when fewer than two places are free, is dropped whole and sets request bit 2 (overflow).
- R10: A pop while the store is empty changes nothing in the store and sets request bit 3 (underflow).
- R11: The trigger output is 1 exactly while the fill count is strictly greater than the trigger level. The DMA request equals the trigger output ANDed with the DMA enable.
- R12: Request bits are ordered as trigger (0), not-empty (1), overflow (2), underflow (3). A request bit is set one cycle after its event or after a 1 on the matching set input. It is cleared by a 1 on the matching clear input, but set and events win over clear. Trigger and not-empty are set again every cycle their condition holds. The masked view is the request ANDed with the mask, and the interrupt line is the OR of the masked view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ch_mode | input | 2 | 0 off, 1 left, 2 right, 3 stereo pair |
| cfg_word_len | input | 2 | 0:16, 1:18, 2:20, 3:24 bits |
| cfg_sign_ext | input | 1 | 1 widens with the sign bit, 0 with zeros |
| cfg_trig_level | input | 8 | Trigger threshold |
| cfg_clear | input | 1 | Held flush |
| cfg_freeze | input | 1 | Drop converter writes |
| cfg_dma_en | input | 1 | DMA request enable |
| smp_valid | input | 1 | Sample strobe from converter |
| smp_left | input | 24 | Left sample, low-aligned |
| smp_right | input | 24 | Right sample, low-aligned |
| pop | input | 1 | Remove head entry |
| head_data | output | 32 | Oldest entry (peek view) |
| fill_count | output | 8 | Entries held |
| wr_ptr | output | 8 | Write pointer |
| rd_ptr | output | 8 | Read pointer |
| trig | output | 1 | Fill count above level |
| dma_req | output | 1 | Gated trigger |
| irq_set | input | 4 | Set request bits |
| irq_clr | input | 4 | Clear request bits (write 1) |
| irq_mask | input | 4 | Interrupt mask |
| irq_req | output | 4 | Request register |
| irq_masked | output | 4 | Request AND mask |
| irq | output | 1 | OR of masked view |

## Verification
The store is exercised with runs of mono writes in each word length under both extension modes, using random samples. Some runs keep the top significant bit at 1, so that zero and sign widening produce different results. Stereo writes with distinct left and right values confirm the pair order. A long stereo fill that runs into the full boundary separates pair-level overflow from single-entry overflow. A full drain that ends with an extra pop on the empty store exercises pointer wrap and underflow. Clear, freeze and the interrupt set, clear and mask inputs are each applied while writes or pops are also present, so each effect shows up against ordinary traffic.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
   typedef enum logic [1:0] {CH_OFF = 2'd0, CH_LEFT = 2'd1, CH_RIGHT = 2'd2, CH_PAIR = 2'd3} ch_mode_e;

   localparam int IRQ_TRIG   = 0;
   localparam int IRQ_NEMPTY = 1;
   localparam int IRQ_OVF    = 2;
   localparam int IRQ_UDF    = 3;
   localparam int IRQ_N      = 4;

   // significant bits for a word length code
   function automatic int wl_bits(input int code);
      case (code)
         0:       return 16;
         1:       return 18;
         2:       return 20;
         default: return 24;
      endcase
   endfunction
endpackage

// File: rtl/pcm_rx_widen.sv
module pcm_rx_widen #(
   parameter int IN_W  = 24,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  smp,
   input  logic [1:0]       len,
   input  logic             sext,
   output logic [OUT_W-1:0] word
);
   if (IN_W < 24 || OUT_W < IN_W) begin : g_bad
      $error("pcm_rx_widen: IN_W must be >= 24 and OUT_W >= IN_W");
   end

   logic [OUT_W-1:0] cand [4];

   for (genvar k = 0; k < 4; k++) begin : g_len
      localparam int W = pcm_rx_pkg::wl_bits(k);
      assign cand[k] = {{(OUT_W-W){sext & smp[W-1]}}, smp[W-1:0]};
   end

   assign word = cand[len];
endmodule

// File: rtl/pcm_rx_store.sv
module pcm_rx_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 255,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [1:0]    n_wr,
   input  logic [DW-1:0] d0,
   input  logic [DW-1:0] d1,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr
);
   if (DEPTH < 2) begin : g_bad
      $error("pcm_rx_store: DEPTH must be at least 2");
   end

   function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   logic [DW-1:0] mem [DEPTH];
   logic [CW:0]   cnt_nx;

   assign cnt_nx = {1'b0, count} + (CW+1)'(n_wr) - (CW+1)'(pop);
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (n_wr != 2'd0) mem[wr_ptr]      <= d0;
      if (n_wr == 2'd2) mem[inc(wr_ptr)] <= d1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (flush) begin
         count  <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         count <= cnt_nx[CW-1:0];
         if (n_wr == 2'd1)      wr_ptr <= inc(wr_ptr);
         else if (n_wr == 2'd2) wr_ptr <= inc(inc(wr_ptr));
         if (pop)               rd_ptr <= inc(rd_ptr);
      end
   end

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> {1'b0, count} == {1'b0, $past(count)} + (CW+1)'($past(n_wr)) - (CW+1)'($past(pop)));
   a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && wr_ptr == '0 && rd_ptr == '0));
   a_r10_pop_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/pcm_rx_irq.sv
module pcm_rx_irq #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] req,
   output logic [N-1:0] masked,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= '0;
      else        req <= (req & ~clr) | set | ev;
   end

   assign masked = req & mask;
   assign irq    = |masked;

   a_r12_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set | ev)) |=> ((req & $past(set | ev)) == $past(set | ev)));
   a_r12_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~set & ~ev)) |=> ((req & $past(clr & ~set & ~ev)) == '0));
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((set | ev | clr) == '0) |=> $stable(req));
endmodule

// File: rtl/pcm_rx_fifo.sv
module pcm_rx_fifo #(
   parameter int IN_W  = 24,
   parameter int DW    = 32,
   parameter int DEPTH = 255,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_ch_mode,
   input  logic [1:0]      cfg_word_len,
   input  logic            cfg_sign_ext,
   input  logic [CW-1:0]   cfg_trig_level,
   input  logic            cfg_clear,
   input  logic            cfg_freeze,
   input  logic            cfg_dma_en,
   input  logic            smp_valid,
   input  logic [IN_W-1:0] smp_left,
   input  logic [IN_W-1:0] smp_right,
   input  logic            pop,
   output logic [DW-1:0]   head_data,
   output logic [CW-1:0]   fill_count,
   output logic [PW-1:0]   wr_ptr,
   output logic [PW-1:0]   rd_ptr,
   output logic            trig,
   output logic            dma_req,
   input  logic [3:0]      irq_set,
   input  logic [3:0]      irq_clr,
   input  logic [3:0]      irq_mask,
   output logic [3:0]      irq_req,
   output logic [3:0]      irq_masked,
   output logic            irq
);
   import pcm_rx_pkg::*;

   logic [DW-1:0] w_left, w_right, d0;
   logic [1:0]    n_req, n_wr;
   logic [CW:0]   room;
   logic          ovf, udf, do_pop;
   logic [IRQ_N-1:0] ev;

   pcm_rx_widen #(.IN_W(IN_W), .OUT_W(DW)) u_wl (
      .smp(smp_left), .len(cfg_word_len), .sext(cfg_sign_ext), .word(w_left));
   pcm_rx_widen #(.IN_W(IN_W), .OUT_W(DW)) u_wr (
      .smp(smp_right), .len(cfg_word_len), .sext(cfg_sign_ext), .word(w_right));

   always_comb begin
      if (!smp_valid || cfg_clear || cfg_freeze || cfg_ch_mode == CH_OFF) n_req = 2'd0;
      else if (cfg_ch_mode == CH_PAIR)                                    n_req = 2'd2;
      else                                                                n_req = 2'd1;
   end

   assign room   = (CW+1)'(DEPTH) - {1'b0, fill_count};
   assign ovf    = (n_req != 2'd0) && ((CW+1)'(n_req) > room);
   assign n_wr   = ovf ? 2'd0 : n_req;
   assign d0     = (cfg_ch_mode == CH_RIGHT) ? w_right : w_left;
   assign udf    = pop && !cfg_clear && (fill_count == '0);
   assign do_pop = pop && !cfg_clear && (fill_count != '0);

   pcm_rx_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(cfg_clear), .n_wr(n_wr),
      .d0(d0), .d1(w_right), .pop(do_pop), .head(head_data),
      .count(fill_count), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

   assign trig    = fill_count > cfg_trig_level;
   assign dma_req = trig & cfg_dma_en;

   always_comb begin
      ev             = '0;
      ev[IRQ_TRIG]   = trig;
      ev[IRQ_NEMPTY] = fill_count != '0;
      ev[IRQ_OVF]    = ovf;
      ev[IRQ_UDF]    = udf;
   end

   pcm_rx_irq #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .ev(ev), .set(irq_set), .clr(irq_clr),
      .mask(irq_mask), .req(irq_req), .masked(irq_masked), .irq(irq));

   a_r8_freeze_holds_wp: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_freeze && !cfg_clear) |=> (wr_ptr == $past(wr_ptr)));
   a_r9_ovf_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (wr_ptr == $past(wr_ptr) && irq_req[IRQ_OVF]));
   a_r10_udf_holds: assert property (@(posedge clk) disable iff (!rst_n)
      udf |=> (rd_ptr == $past(rd_ptr) && irq_req[IRQ_UDF]));
   a_r11_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dma_en |-> !dma_req);
endmodule

// File: tb/pcm_rx_fifo_bench.sv
module pcm_rx_fifo_bench;
   localparam int DEPTH = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_ch_mode = 2'd0, cfg_word_len = 2'd0;
   logic        cfg_sign_ext = 1'b0, cfg_clear = 1'b0, cfg_freeze = 1'b0, cfg_dma_en = 1'b0;
   logic [7:0]  cfg_trig_level = 8'd0;
   logic        smp_valid = 1'b0, pop = 1'b0;
   logic [23:0] smp_left = '0, smp_right = '0;
   logic [3:0]  irq_set = '0, irq_clr = '0, irq_mask = '0;
   logic [31:0] head_data;
   logic [7:0]  fill_count, wr_ptr, rd_ptr;
   logic        trig, dma_req, irq;
   logic [3:0]  irq_req, irq_masked;

   pcm_rx_fifo u_pcm_rx_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_ch_mode(cfg_ch_mode), .cfg_word_len(cfg_word_len),
      .cfg_sign_ext(cfg_sign_ext), .cfg_trig_level(cfg_trig_level), .cfg_clear(cfg_clear),
      .cfg_freeze(cfg_freeze), .cfg_dma_en(cfg_dma_en), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right), .pop(pop), .head_data(head_data),
      .fill_count(fill_count), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .trig(trig),
      .dma_req(dma_req), .irq_set(irq_set), .irq_clr(irq_clr), .irq_mask(irq_mask),
      .irq_req(irq_req), .irq_masked(irq_masked), .irq(irq));

   always #2 clk = ~clk;   // 250 MHz

   int unsigned q[$];
   int   m_wp = 0, m_rp = 0;
   logic [3:0] m_req = '0;
   int   vectors = 0, miscompares = 0, cycles = 0;
   string phase = "R1 reset";

   function automatic logic [31:0] widen(input logic [23:0] s, input logic [1:0] wl, input logic sx);
      int w = (wl == 0) ? 16 : (wl == 1) ? 18 : (wl == 2) ? 20 : 24;
      longint v = longint'(s) % (longint'(1) << w);
      if (sx && ((v >> (w - 1)) & 1) == 1) v = v - (longint'(1) << w);
      return v[31:0];
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_wp = 0; m_rp = 0; m_req = '0;
      end else begin
         int nreq, sz;
         logic ovf, udf;
         logic [3:0] ev;
         sz = q.size();
         nreq = (!smp_valid || cfg_clear || cfg_freeze || cfg_ch_mode == 0) ? 0 :
                (cfg_ch_mode == 3) ? 2 : 1;
         ovf = (nreq > 0) && (nreq > DEPTH - sz);
         udf = pop && !cfg_clear && sz == 0;
         ev = {udf, ovf, sz != 0, sz > int'(cfg_trig_level)};
         if (cfg_clear) begin
            q.delete(); m_wp = 0; m_rp = 0;
         end else begin
            if (pop && sz > 0) begin
               void'(q.pop_front()); m_rp = (m_rp + 1) % DEPTH;
            end
            if (!ovf && nreq == 1) begin
               q.push_back(widen(cfg_ch_mode == 2 ? smp_right : smp_left, cfg_word_len, cfg_sign_ext));
               m_wp = (m_wp + 1) % DEPTH;
            end else if (!ovf && nreq == 2) begin
               q.push_back(widen(smp_left, cfg_word_len, cfg_sign_ext));
               q.push_back(widen(smp_right, cfg_word_len, cfg_sign_ext));
               m_wp = (m_wp + 2) % DEPTH;
            end
         end
         m_req = (m_req & ~irq_clr) | irq_set | ev;
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
      end
   endtask

   task automatic check_all();
      logic t = q.size() > int'(cfg_trig_level);
      cmp("R6 fill_count", 32'(fill_count), q.size());
      cmp("R6 wr_ptr", 32'(wr_ptr), m_wp);
      cmp("R6 rd_ptr", 32'(rd_ptr), m_rp);
      if (q.size() > 0) cmp("R5 head_data", head_data, q[0]);
      cmp("R11 trig", 32'(trig), 32'(t));
      cmp("R11 dma_req", 32'(dma_req), 32'(t & cfg_dma_en));
      cmp("R12 irq_req", 32'(irq_req), 32'(m_req));
      cmp("R12 irq_masked", 32'(irq_masked), 32'(m_req & irq_mask));
      cmp("R12 irq", 32'(irq), 32'(|(m_req & irq_mask)));
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
      check_all();
      smp_valid = 0; pop = 0; irq_set = '0; irq_clr = '0;
   endtask

   task automatic wr(input logic [23:0] l, input logic [23:0] r);
      smp_valid = 1; smp_left = l; smp_right = r; tick();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         miscompares++;
         $display("FAIL watchdog expired [%s]", phase);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all();                       // R1 reset values
      rst_n = 1;
      tick();

      phase = "R2 R4 mono left, all lengths";
      cfg_ch_mode = 2'd1; cfg_trig_level = 8'd3; cfg_dma_en = 1;
      for (int k = 0; k < 8; k++) begin
         cfg_word_len = 2'(k % 4); cfg_sign_ext = k[2];
         wr($urandom | 24'h8AAAAA, $urandom);
         wr($urandom & 24'h7FFF, $urandom);
      end
      phase = "R5 pop and peek";
      for (int k = 0; k < 6; k++) begin
         tick();                         // peek only
         pop = 1; tick();
      end
      phase = "R2 mono right and off mode";
      cfg_ch_mode = 2'd2;
      for (int k = 0; k < 4; k++) wr($urandom, $urandom | 24'h800000);
      cfg_ch_mode = 2'd0;
      for (int k = 0; k < 4; k++) wr($urandom, $urandom);

      phase = "R3 stereo pairs";
      cfg_ch_mode = 2'd3; cfg_word_len = 2'd3; cfg_sign_ext = 1;
      for (int k = 0; k < 4; k++) begin
         wr(24'h100000 + 24'(k), 24'hF00000 + 24'(k));
         pop = 1; tick();
      end

      phase = "R9 R11 fill to full";
      cfg_trig_level = 8'd200;
      while (fill_count < 8'd254) begin
         if (fill_count == 8'd150) cfg_dma_en = 0;
         if (fill_count == 8'd210) cfg_dma_en = 1;
         wr($urandom, $urandom);
      end
      wr(24'h1, 24'h2);                  // R9 pair with one place free
      cfg_ch_mode = 2'd1;
      wr(24'h3, 24'h0);                  // fills last place
      wr(24'h4, 24'h0);                  // R9 mono to full
      irq_clr = 4'hF; tick();

      phase = "R6 R10 drain and underflow";
      while (fill_count != 0) begin pop = 1; tick(); end
      pop = 1; tick();                   // R10 pop on empty
      pop = 1; tick();

      phase = "R8 freeze";
      cfg_freeze = 1;
      for (int k = 0; k < 3; k++) wr($urandom, $urandom);
      cfg_freeze = 0;
      wr(24'h55AA, 24'h0);
      cfg_freeze = 1; pop = 1; tick();
      cfg_freeze = 0;

      phase = "R7 held clear";
      for (int k = 0; k < 5; k++) wr($urandom, $urandom);
      cfg_clear = 1;
      for (int k = 0; k < 4; k++) begin pop = 1; wr($urandom, $urandom); end
      cfg_clear = 0;
      wr(24'h0ABCDE, 24'h0);
      wr(24'h012345, 24'h0);

      phase = "R12 set clear mask";
      irq_clr = 4'hF; tick();
      irq_mask = 4'b1100; irq_set = 4'b0100; tick();
      tick();
      irq_clr = 4'b0100; tick();
      irq_set = 4'b1000; irq_clr = 4'b1000; tick();
      irq_mask = 4'b0011; tick();
      while (fill_count != 0) begin pop = 1; tick(); end
      irq_clr = 4'hF; tick();
      tick();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule